// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block schedules a run of conversions over eight multiplexed input channels. It drives one external conversion engine and stores the formatted results in eight result slots. Software configures it through a small word-addressed register interface with a write strobe and a combinational read port. One word holds power, interrupt enable and trigger enable. Further words hold the run length, the conversion resolution and the run mode. The run mode selects the first channel, whether the channel stays fixed or steps, whether runs repeat, and the result format.

Writing the power, length or resolution word cancels any run in progress and leaves the block idle. Writing the mode word cancels the current run and begins a fresh one. If the trigger is enabled, that fresh run waits for a rising edge on the trigger input. A status word reports run completion, trigger overrun and the slot counter. A second status word reports one completion flag per slot. A level interrupt follows the completion flag when interrupts are enabled.

Top module: `mcseq_top`

## Requirements
- R1: After reset every configuration word (addresses 0 to 3), both status words (addresses 4 and 5) and all result slots (addresses 8 to 15) read 0, and irq is 0.
- R2: A write to address 0 (bit0 power, bit1 interrupt enable, bit2 trigger enable), address 1 (bits[2:0] run length) or address 2 (bit0 = 1 selects 8-bit resolution) cancels a running run. It pulses eng_abort and issues no further eng_start until the next mode write.
- R3: A write to address 3 (bits[2:0] first channel, bit3 stepping, bit4 repeat, bit5 signed, bit6 left-justified) cancels any run. If power is on, stop_req is low and the trigger is disabled, it starts a new run at once. The start clears the completion flag, the overrun flag, the slot counter and all slot flags. eng_start is a one-cycle pulse.
- R4: A run performs N conversions, where N is the run-length field and a value of 0 means 8. Conversion k is stored in slot k (address 8+k) and sets bit k of the status word at address 5. Slots at or beyond N keep their previous contents.
- R5: With stepping off, every conversion of a run selects the first channel.
- R6: With stepping on, conversion k selects channel (first + k) mod 8, wrapping from 7 to 0.
- R7: With repeat off, the block goes idle after one run. With repeat on, it begins the next run on its own until cancelled.
- R8: The result word is formed from a 10-bit code, or from the code's upper 8 bits in 8-bit resolution. Signed format inverts the code's MSB. Right-justified places the code in the low bits, zero-extended when unsigned and sign-extended when signed. Left-justified places the code in the top bits with zeros below.
- R9: With power off no conversion starts. A high stop_req cancels a running run, blocks new runs, and lowering it again does not restart anything.
- R10: With the trigger enabled, a started run issues nothing until a rising edge on trig_in. A rising edge while conversions are in progress sets the overrun flag.
- R11: The status word at address 4 holds the completion flag in bit7, the overrun flag in bit6 and the slot counter in bits[2:0]. The counter holds its value when a run is cancelled and returns to 0 when a run completes. Writing 1 to bit7 or bit6 clears that flag.
- R12: irq is high exactly while the completion flag is set and interrupts are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| trig_in | input | 1 | External trigger, rising edge active |
| stop_req | input | 1 | Stop request, cancels and blocks conversions |
| eng_start | output | 1 | One-cycle start to the conversion engine |
| eng_abort | output | 1 | Tells the engine to drop a conversion in progress |
| eng_chan | output | 3 | Channel select for the conversion being started |
| eng_done | input | 1 | Engine result valid pulse |
| eng_data | input | 10 | Engine unsigned result code |
| irq | output | 1 | Run-complete interrupt |

## Verification
On every cycle the assertions check several rules. A start is never issued without power or under a stop request, and a start is always a single-cycle pulse. A stop request or a write to a plain configuration word leaves the sequencer idle on the next cycle. In fixed-channel mode each start selects the first channel. The completion flag rises only on an engine result, and the interrupt never stands without that flag. The bench scenarios cover what needs a whole run to show: channel stepping with wrap, the run-length encoding of 0, the four result formats at both resolutions, repeat versus single runs, trigger gating and overrun, counter retention on cancellation, and the write-one clearing of the flags.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  localparam int NCH  = 8;
  localparam int CHW  = $clog2(NCH);
  localparam int CW   = 10;
  localparam int C8W  = 8;
  localparam int DW   = 16;
  localparam int AW   = 4;

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_LEN  = 4'd1;
  localparam logic [AW-1:0] A_RES  = 4'd2;
  localparam logic [AW-1:0] A_MODE = 4'd3;
  localparam logic [AW-1:0] A_ST0  = 4'd4;
  localparam logic [AW-1:0] A_ST1  = 4'd5;

  typedef struct packed {
    logic trig_en;
    logic irq_en;
    logic pwr;
  } ctrl_t;

  typedef struct packed {
    logic           left;
    logic           sgn;
    logic           cont;
    logic           multi;
    logic [CHW-1:0] first;
  } mode_t;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_ISSUE, S_WAIT} seq_st_t;
endpackage

// File: rtl/mcseq_regs.sv
module mcseq_regs
  import mcseq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic                    seq_done,
  input  logic                    ovr,
  input  logic [CHW-1:0]          cnt,
  input  logic [NCH-1:0]          cc,
  input  logic [NCH-1:0][DW-1:0]  res,
  output ctrl_t                   ctrl,
  output logic [CHW-1:0]          len_code,
  output logic                    res8,
  output mode_t                   mode,
  output logic                    abort_req,
  output logic                    start_req,
  output logic                    clr_done,
  output logic                    clr_ovr,
  output logic [DW-1:0]           rdata
);
  logic wr_ctrl, wr_len, wr_res, wr_mode, wr_st0;
  ctrl_t          ctrl_d;
  logic [CHW-1:0] len_d;
  logic           res8_d;
  mode_t          mode_d;
  logic           unused_wdata;

  assign unused_wdata = ^wdata[DW-1:C8W];

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_len  = wr_en && (addr == A_LEN);
  assign wr_res  = wr_en && (addr == A_RES);
  assign wr_mode = wr_en && (addr == A_MODE);
  assign wr_st0  = wr_en && (addr == A_ST0);

  assign abort_req = wr_ctrl | wr_len | wr_res | wr_mode;
  assign start_req = wr_mode;
  assign clr_done  = wr_st0 & wdata[7];
  assign clr_ovr   = wr_st0 & wdata[6];

  always_comb begin
    ctrl_d = ctrl;
    len_d  = len_code;
    res8_d = res8;
    mode_d = mode;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
    if (wr_len)  len_d  = wdata[CHW-1:0];
    if (wr_res)  res8_d = wdata[0];
    if (wr_mode) mode_d = mode_t'(wdata[$bits(mode_t)-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      len_code <= '0;
      res8     <= 1'b0;
      mode     <= '0;
    end else begin
      if (wr_ctrl) ctrl     <= ctrl_d;
      if (wr_len)  len_code <= len_d;
      if (wr_res)  res8     <= res8_d;
      if (wr_mode) mode     <= mode_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[AW-1]) begin
      rdata = res[addr[CHW-1:0]];
    end else begin
      case (addr)
        A_CTRL: rdata[$bits(ctrl_t)-1:0] = ctrl;
        A_LEN:  rdata[CHW-1:0]           = len_code;
        A_RES:  rdata[0]                 = res8;
        A_MODE: rdata[$bits(mode_t)-1:0] = mode;
        A_ST0:  begin
          rdata[7]       = seq_done;
          rdata[6]       = ovr;
          rdata[CHW-1:0] = cnt;
        end
        A_ST1:  rdata[NCH-1:0] = cc;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mcseq_fsm.sv
module mcseq_fsm
  import mcseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic           abort_req,
  input  logic           pwr,
  input  logic           stop_req,
  input  logic           trig_en,
  input  logic           trig_rise,
  input  logic [CHW-1:0] len_code,
  input  mode_t          mode,
  input  logic           eng_done,
  input  logic           clr_done,
  input  logic           clr_ovr,
  output logic           eng_start,
  output logic           eng_abort,
  output logic [CHW-1:0] eng_chan,
  output logic           store_en,
  output logic [CHW-1:0] cnt,
  output logic           seq_done,
  output logic           ovr,
  output logic           busy,
  output logic           go
);
  seq_st_t        st, st_d;
  logic [CHW-1:0] cnt_d, last;
  logic           done_d, ovr_d, kill, active;

  assign last   = len_code - 1'b1;
  assign kill   = abort_req | stop_req | ~pwr;
  assign go     = start_req & pwr & ~stop_req;
  assign active = (st == S_ISSUE) || (st == S_WAIT);
  assign busy   = (st != S_IDLE);

  always_comb begin
    st_d     = st;
    cnt_d    = cnt;
    done_d   = seq_done;
    ovr_d    = ovr;
    store_en = 1'b0;
    if (clr_done) done_d = 1'b0;
    if (clr_ovr)  ovr_d  = 1'b0;
    if (trig_en && trig_rise && active) ovr_d = 1'b1;
    if (go) begin
      st_d   = trig_en ? S_ARM : S_ISSUE;
      cnt_d  = '0;
      done_d = 1'b0;
      ovr_d  = 1'b0;
    end else if (kill) begin
      st_d = S_IDLE;
    end else begin
      case (st)
        S_ARM:   if (trig_rise) st_d = S_ISSUE;
        S_ISSUE: st_d = S_WAIT;
        S_WAIT:  if (eng_done) begin
          store_en = 1'b1;
          if (cnt == last) begin
            cnt_d  = '0;
            done_d = 1'b1;
            if (mode.cont) st_d = trig_en ? S_ARM : S_ISSUE;
            else           st_d = S_IDLE;
          end else begin
            cnt_d = cnt + 1'b1;
            st_d  = S_ISSUE;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      seq_done <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      st       <= st_d;
      cnt      <= cnt_d;
      seq_done <= done_d;
      ovr      <= ovr_d;
    end
  end

  assign eng_start = (st == S_ISSUE) && !kill;
  assign eng_abort = abort_req | ((stop_req | ~pwr) & busy);
  assign eng_chan  = mode.multi ? (mode.first + cnt) : mode.first;
endmodule

// File: rtl/mcseq_fmt.sv
module mcseq_fmt
  import mcseq_pkg::*;
(
  input  logic [CW-1:0] raw,
  input  logic          res8,
  input  logic          sgn,
  input  logic          left,
  output logic [DW-1:0] word
);
  logic [CW-1:0]  c10;
  logic [C8W-1:0] c8;

  always_comb begin
    c10 = raw;
    c8  = raw[CW-1 -: C8W];
    c10[CW-1]  = raw[CW-1] ^ sgn;
    c8[C8W-1]  = raw[CW-1] ^ sgn;
    if (res8) begin
      if (left) word = {c8, {(DW-C8W){1'b0}}};
      else      word = {{(DW-C8W){sgn & c8[C8W-1]}}, c8};
    end else begin
      if (left) word = {c10, {(DW-CW){1'b0}}};
      else      word = {{(DW-CW){sgn & c10[CW-1]}}, c10};
    end
  end
endmodule

// File: rtl/mcseq_results.sv
module mcseq_results
  import mcseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   store_en,
  input  logic [CHW-1:0]         store_idx,
  input  logic [DW-1:0]          din,
  input  logic                   clr_cc,
  output logic [NCH-1:0][DW-1:0] res,
  output logic [NCH-1:0]         cc
);
  for (genvar k = 0; k < NCH; k++) begin : g_slot
    logic          hit;
    logic          cc_d;
    logic [DW-1:0] res_d;

    assign hit = store_en && (store_idx == CHW'(k));

    always_comb begin
      res_d = res[k];
      cc_d  = cc[k];
      if (clr_cc) cc_d = 1'b0;
      if (hit) begin
        res_d = din;
        cc_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res[k] <= '0;
        cc[k]  <= 1'b0;
      end else begin
        if (hit) res[k] <= res_d;
        if (hit || clr_cc) cc[k] <= cc_d;
      end
    end
  end
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top
  import mcseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic           trig_in,
  input  logic           stop_req,
  output logic           eng_start,
  output logic           eng_abort,
  output logic [CHW-1:0] eng_chan,
  input  logic           eng_done,
  input  logic [CW-1:0]  eng_data,
  output logic           irq
);
  logic rst_s0, rst_sync_n;
  logic trig_q, trig_rise;

  ctrl_t                  ctrl;
  mode_t                  mode;
  logic [CHW-1:0]         len_code, cnt;
  logic                   res8, abort_req, start_req, clr_done, clr_ovr;
  logic                   seq_done, ovr, busy, go, store_en, pwr;
  logic [NCH-1:0]         cc;
  logic [NCH-1:0][DW-1:0] res;
  logic [DW-1:0]          fmt_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) trig_q <= 1'b0;
    else             trig_q <= trig_in;
  end
  assign trig_rise = trig_in & ~trig_q;
  assign pwr       = ctrl.pwr;

  mcseq_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .seq_done(seq_done), .ovr(ovr), .cnt(cnt), .cc(cc), .res(res),
    .ctrl(ctrl), .len_code(len_code), .res8(res8), .mode(mode),
    .abort_req(abort_req), .start_req(start_req), .clr_done(clr_done),
    .clr_ovr(clr_ovr), .rdata(rdata)
  );

  mcseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start_req(start_req), .abort_req(abort_req),
    .pwr(pwr), .stop_req(stop_req), .trig_en(ctrl.trig_en), .trig_rise(trig_rise),
    .len_code(len_code), .mode(mode), .eng_done(eng_done), .clr_done(clr_done),
    .clr_ovr(clr_ovr), .eng_start(eng_start), .eng_abort(eng_abort),
    .eng_chan(eng_chan), .store_en(store_en), .cnt(cnt), .seq_done(seq_done),
    .ovr(ovr), .busy(busy), .go(go)
  );

  mcseq_fmt u_fmt (
    .raw(eng_data), .res8(res8), .sgn(mode.sgn), .left(mode.left), .word(fmt_word)
  );

  mcseq_results u_res (
    .clk(clk), .rst_n(rst_sync_n), .store_en(store_en), .store_idx(cnt),
    .din(fmt_word), .clr_cc(go), .res(res), .cc(cc)
  );

  assign irq = seq_done & ctrl.irq_en;
endmodule

// File: rtl/mcseq_chk.sv
module mcseq_chk
  import mcseq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           stop_req,
  input logic           pwr,
  input logic           busy,
  input logic           eng_start,
  input logic [CHW-1:0] eng_chan,
  input logic           multi,
  input logic [CHW-1:0] first,
  input logic           eng_done,
  input logic           seq_done,
  input logic           irq
);
  assert_start_powered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (pwr && !stop_req));

  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && busy) |=> !busy);

  assert_cfg_write_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr <= A_RES)) |=> !busy);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !wr_en) |=> !eng_start);

  assert_fixed_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !multi) |-> (eng_chan == first));

  assert_done_from_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(eng_done));

  assert_irq_needs_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> seq_done);
endmodule

bind mcseq_top mcseq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .stop_req(stop_req),
  .pwr(pwr), .busy(busy), .eng_start(eng_start), .eng_chan(eng_chan),
  .multi(mode.multi), .first(mode.first), .eng_done(eng_done),
  .seq_done(seq_done), .irq(irq)
);

// File: tb/sim_mcseq_top.sv
`timescale 1ns/1ps
module sim_mcseq_top;
  logic        clk, rst_n, wr_en, trig_in, stop_req, eng_done;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;
  logic        eng_start, eng_abort, irq;
  logic [2:0]  eng_chan;
  logic [9:0]  eng_data;

  int checks = 0, failures = 0;
  int nstart = 0, nabort = 0;
  logic [2:0] chlog [0:63];
  logic [9:0] dseed = 10'd13;
  logic       ebusy = 1'b0;
  int         ecnt = 0;
  logic [2:0] ech = '0;
  bit         finished = 0;

  mcseq_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trig_in(trig_in), .stop_req(stop_req), .eng_start(eng_start),
    .eng_abort(eng_abort), .eng_chan(eng_chan), .eng_done(eng_done),
    .eng_data(eng_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [9:0] dval(input logic [2:0] ch);
    return 10'((int'(ch) * 97 + int'(dseed)) % 1024);
  endfunction

  initial begin
    eng_done = 1'b0;
    eng_data = '0;
  end

  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) begin
      chlog[nstart % 64] <= eng_chan;
      nstart <= nstart + 1;
    end
    if (eng_abort) nabort <= nabort + 1;
    if (eng_abort) ebusy <= 1'b0;
    else if (eng_start) begin
      ebusy <= 1'b1; ecnt <= 3; ech <= eng_chan;
    end else if (ebusy) begin
      if (ecnt == 0) begin
        ebusy <= 1'b0; eng_done <= 1'b1; eng_data <= dval(ech);
      end else ecnt <= ecnt - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_done();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(4'd4, s);
      if (s[7]) return;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      if (a < 6 || a >= 8) chk("R1 reset word", 32'(v), 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_fixed();
    logic [15:0] v;
    int base;
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'h0003);
    base = nstart;
    wr(4'd3, 16'h0005);
    wait_done();
    chk("R4 three conversions", 32'(nstart - base), 32'd3);
    for (int k = 0; k < 3; k++) begin
      chk("R5 fixed channel", 32'(chlog[(base + k) % 64]), 32'd5);
      rd(4'(8 + k), v);
      chk("R4 slot value", 32'(v), 32'(dval(3'd5)));
    end
    rd(4'd11, v);
    chk("R4 slot beyond length untouched", 32'(v), 32'h0);
    rd(4'd5, v);
    chk("R4 slot flags", 32'(v), 32'h07);
    rd(4'd4, v);
    chk("R11 status after run", 32'(v), 32'h80);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    int base;
    dseed = 10'd200;
    wr(4'd1, 16'h0000);
    base = nstart;
    wr(4'd3, 16'h000E);
    wait_done();
    chk("R4 length code 0 means 8", 32'(nstart - base), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk("R6 stepping channel", 32'(chlog[(base + k) % 64]), 32'((6 + k) % 8));
      rd(4'(8 + k), v);
      chk("R6 slot value", 32'(v), 32'(dval(3'((6 + k) % 8))));
    end
    rd(4'd5, v);
    chk("R4 all slot flags", 32'(v), 32'hFF);
  endtask

  task automatic fmt_one(input logic [9:0] code, input logic r8, input logic [15:0] m,
                         input logic [15:0] exp, input string tag);
    logic [15:0] v;
    dseed = code;
    wr(4'd2, {15'd0, r8});
    wr(4'd1, 16'h0001);
    wr(4'd3, m);
    wait_done();
    rd(4'd8, v);
    chk(tag, 32'(v), 32'(exp));
  endtask

  task automatic t_format();
    fmt_one(10'h2A5, 1'b0, 16'h00, 16'h02A5, "R8 right unsigned");
    fmt_one(10'h2A5, 1'b0, 16'h20, 16'h00A5, "R8 right signed positive");
    fmt_one(10'h0A5, 1'b0, 16'h20, 16'hFEA5, "R8 right signed negative");
    fmt_one(10'h2A5, 1'b0, 16'h40, 16'hA940, "R8 left unsigned");
    fmt_one(10'h2A5, 1'b0, 16'h60, 16'h2940, "R8 left signed");
    fmt_one(10'h2A5, 1'b1, 16'h00, 16'h00A9, "R8 8-bit right unsigned");
    fmt_one(10'h2A5, 1'b1, 16'h20, 16'h0029, "R8 8-bit right signed");
    fmt_one(10'h2A5, 1'b1, 16'h40, 16'hA900, "R8 8-bit left unsigned");
    wr(4'd2, 16'h0000);
  endtask

  task automatic t_continuous();
    logic [15:0] v;
    int base, ab, t;
    wr(4'd1, 16'h0002);
    base = nstart;
    wr(4'd3, 16'h0011);
    t = 0;
    while (nstart - base < 5 && t < 500) begin @(negedge clk); t++; end
    chk("R7 repeat keeps running", 32'(nstart - base >= 5), 32'd1);
    ab = nabort;
    wr(4'd0, 16'h0001);
    base = nstart;
    chk("R2 cancel pulses abort", 32'(nabort - ab), 32'd1);
    idle(50);
    chk("R2 no restart after power word write", 32'(nstart - base), 32'd0);
    base = nstart;
    wr(4'd3, 16'h0001);
    wait_done();
    idle(40);
    chk("R7 single run stops", 32'(nstart - base), 32'd2);
  endtask

  task automatic t_len_abort();
    logic [15:0] v;
    int base, t;
    wr(4'd1, 16'h0000);
    base = nstart;
    wr(4'd3, 16'h0000);
    t = 0;
    while (nstart - base < 3 && t < 500) begin @(negedge clk); t++; end
    wr(4'd1, 16'h0005);
    base = nstart;
    idle(40);
    chk("R2 no start after length write", 32'(nstart - base), 32'd0);
    rd(4'd4, v);
    chk("R2 run not completed", 32'(v[7]), 32'd0);
  endtask

  task automatic t_power_stop();
    logic [15:0] v;
    int base, t;
    wr(4'd0, 16'h0000);
    base = nstart;
    wr(4'd3, 16'h0000);
    idle(40);
    chk("R9 no start while unpowered", 32'(nstart - base), 32'd0);
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'h0000);
    base = nstart;
    wr(4'd3, 16'h0000);
    t = 0;
    while (nstart - base < 2 && t < 500) begin @(negedge clk); t++; end
    stop_req = 1'b1;
    idle(30);
    chk("R9 stop cancels run", 32'(nstart - base), 32'd2);
    rd(4'd4, v);
    chk("R11 counter held on cancel", 32'(v[2:0]), 32'd1);
    wr(4'd3, 16'h0000);
    idle(20);
    chk("R9 mode write blocked by stop", 32'(nstart - base), 32'd2);
    stop_req = 1'b0;
    idle(30);
    chk("R9 no restart after stop released", 32'(nstart - base), 32'd2);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic t_trigger();
    logic [15:0] v;
    int base, t;
    wr(4'd0, 16'h0005);
    wr(4'd1, 16'h0004);
    base = nstart;
    wr(4'd3, 16'h0008);
    idle(20);
    chk("R10 waits for trigger", 32'(nstart - base), 32'd0);
    pulse_trig();
    t = 0;
    while (nstart - base < 1 && t < 100) begin @(negedge clk); t++; end
    pulse_trig();
    wait_done();
    chk("R10 run after trigger", 32'(nstart - base), 32'd4);
    rd(4'd4, v);
    chk("R10 overrun set", 32'(v), 32'hC0);
    wr(4'd4, 16'h0040);
    rd(4'd4, v);
    chk("R11 overrun cleared by write", 32'(v), 32'h80);
    wr(4'd0, 16'h0001);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(4'd0, 16'h0003);
    wr(4'd1, 16'h0001);
    wr(4'd3, 16'h0000);
    wait_done();
    @(negedge clk);
    chk("R12 irq with enable", 32'(irq), 32'd1);
    wr(4'd4, 16'h0080);
    rd(4'd4, v);
    chk("R11 done cleared by write", 32'(v[7]), 32'd0);
    chk("R12 irq cleared", 32'(irq), 32'd0);
    wr(4'd0, 16'h0001);
    wr(4'd3, 16'h0000);
    wait_done();
    @(negedge clk);
    chk("R12 no irq when disabled", 32'(irq), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    trig_in = 1'b0; stop_req = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_fixed();
    t_wrap();
    t_format();
    t_continuous();
    t_len_abort();
    t_power_stop();
    t_trigger();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule